// File: doc/BRIEF.md
# Dual Prescaled Down-Counting Timer

This peripheral holds a pair of independent 24-bit countdown timers behind a single 32-bit register window. Each timer has its own prescaler, which divides the input clock by 1, 16 or 256. A timer can run once and stop at zero, or reload itself and repeat. When a timer's count passes from one to zero, it latches a pending flag. Both flags are merged into one active-high interrupt line, and each flag stays set until software writes that timer's clear register.

Software programs a timer by writing its control word and then its reload value. Writing the reload value also loads the counter and restarts the prescaler, so the first period after the write is always a full one. Software can read the live count at any time. For example, a timer left in repeat mode with the largest reload value serves as a free-running time base.

Top module: `dual_tick_timer`

## Requirements
- R1: After a synchronous reset, every register of both timers reads zero, both counters are stopped and `irq` is low.
- R2: A write to a timer's reload register (offset 0x0) stores the low 24 bits of the data. In the same clock edge it copies them into the counter and restarts the prescaler. The count register (offset 0x4) then reads back that value.
- R3: While enabled, a counter decrements once every 1, 16 or 256 clock cycles. The divisor is set by control bits [3:2] = 0, 1 or 2, and a field value of 3 also divides by 256.
- R4: With control bit 6 clear (run once), the tick that takes the count from 1 to 0 sets the pending flag. The counter then holds 0 until the next reload write.
- R5: With control bit 6 set (repeat), the tick that would take the count from 1 to 0 sets the pending flag and loads the reload value instead. A reload value of L therefore gives one event every L ticks.
- R6: Clearing control bit 7 (enable) freezes the counter and its prescaler. Any pending flag stays set.
- R7: A write of any data to a timer's clear register (offset 0xC) clears only that timer's pending flag. If the flag is being set in the same cycle, the set wins.
- R8: `irq` is the OR of both pending flags, delayed by one register stage.
- R9: The first timer sits at offset 0x00 and the second at 0x20. The control register reads back bit 7, bit 6 and bits [3:2], with all other bits zero. Writes to offsets 0x10 to 0x1C of either timer, and writes with addr[1:0] not zero, are ignored. Those offsets and the clear register read as zero.
- R10: `rd_data` is updated on the clock edge where `rd_en` is high. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte address within the window |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Active-high interrupt, OR of pending flags |

## Verification
The hardest case to reach from the ports is a clear write that lands on the very edge where the count passes from one to zero. The bench arranges this by loading a short run-once count at divide-by-1 and issuing the clear write exactly that many edges later, then checks that the interrupt survives. The reload and run-once cases under every prescale code are covered by random reload values, modes and wait times. For each run, the bench predicts the sampled count from the number of edges elapsed since the reload write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Register offsets inside one timer, as word index addr[3:2]
  localparam logic [1:0] REG_RELOAD = 2'd0;
  localparam logic [1:0] REG_COUNT  = 2'd1;
  localparam logic [1:0] REG_CTRL   = 2'd2;
  localparam logic [1:0] REG_CLEAR  = 2'd3;

  // Control word bit positions
  localparam int CTL_EN_BIT  = 7;
  localparam int CTL_REP_BIT = 6;
  localparam int CTL_PS_LSB  = 2;

  // Prescale codes
  localparam logic [1:0] PS_DIV1  = 2'd0;
  localparam logic [1:0] PS_DIV16 = 2'd1;

  typedef struct packed {
    logic       en;
    logic       rep;
    logic [1:0] ps;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int MID_LOG2 = 4,
  parameter int HI_LOG2  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  import tmr_pkg::*;

  localparam logic [HI_LOG2-1:0] TERM_MID = HI_LOG2'((1 << MID_LOG2) - 1);
  localparam logic [HI_LOG2-1:0] TERM_HI  = '1;

  logic [HI_LOG2-1:0] acc_q;
  logic [HI_LOG2-1:0] term;

  always_comb begin
    case (sel)
      PS_DIV1:  term = '0;
      PS_DIV16: term = TERM_MID;
      default:  term = TERM_HI;
    endcase
  end

  // >= keeps a mid-count divisor change from stalling a full wrap
  assign tick = run && (acc_q >= term);

  always_ff @(posedge clk) begin
    if (rst || restart) acc_q <= '0;
    else if (run)       acc_q <= tick ? '0 : acc_q + 1'b1;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W    = 24,
  parameter int MID_LOG2 = 4,
  parameter int HI_LOG2  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_we,
  input  logic [CNT_W-1:0]    ld_val,
  input  logic                ctl_we,
  input  tmr_pkg::tmr_ctrl_t  ctl_val,
  input  logic                clr_we,
  output logic [CNT_W-1:0]    reload_o,
  output logic [CNT_W-1:0]    count_o,
  output tmr_pkg::tmr_ctrl_t  ctrl_o,
  output logic                pend_o
);
  import tmr_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;
  tmr_ctrl_t        ctrl_q;
  logic             pend_q;
  logic             tick;
  logic             hit;

  tmr_prescaler #(
    .MID_LOG2 (MID_LOG2),
    .HI_LOG2  (HI_LOG2)
  ) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q.en),
    .restart (ld_we),
    .sel     (ctrl_q.ps),
    .tick    (tick)
  );

  assign hit = tick && !ld_we && (count_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      ctrl_q   <= '0;
    end else begin
      if (ld_we)  reload_q <= ld_val;
      if (ctl_we) ctrl_q   <= ctl_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                count_q <= '0;
    else if (ld_we)         count_q <= ld_val;
    else if (tick) begin
      if (count_q == ONE)   count_q <= ctrl_q.rep ? reload_q : '0;
      else if (count_q == '0) begin
        if (ctrl_q.rep)     count_q <= reload_q;
      end else              count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         pend_q <= 1'b0;
    else if (hit)    pend_q <= 1'b1;
    else if (clr_we) pend_q <= 1'b0;
  end

  assign reload_o = reload_q;
  assign count_o  = count_q;
  assign ctrl_o   = ctrl_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer #(
  parameter int N_TMR       = 2,
  parameter int CNT_W       = 24,
  parameter int DATA_W      = 32,
  parameter int STRIDE_LOG2 = 5,
  parameter int MID_LOG2    = 4,
  parameter int HI_LOG2     = 8,
  parameter int ADDR_W      = STRIDE_LOG2 + ((N_TMR > 1) ? $clog2(N_TMR) : 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  import tmr_pkg::*;

  localparam int CH_W = ADDR_W - STRIDE_LOG2;

  logic [CH_W-1:0] a_ch;
  logic [1:0]      a_reg;
  logic            a_ok;

  logic [N_TMR-1:0][CNT_W-1:0] reload_all;
  logic [N_TMR-1:0][CNT_W-1:0] count_all;
  tmr_ctrl_t [N_TMR-1:0]       ctrl_all;
  logic [N_TMR-1:0]            pend_all;
  logic [N_TMR-1:0]            en_all;
  logic [N_TMR-1:0]            rep_all;
  logic [N_TMR-1:0]            ch_sel;
  logic [N_TMR-1:0]            ld_we;
  logic [N_TMR-1:0]            ctl_we;
  logic [N_TMR-1:0]            clr_we;
  logic [DATA_W-1:0]           rd_mux;
  tmr_ctrl_t                   ctl_in;
  logic                        unused_hi;

  assign a_ch  = addr[STRIDE_LOG2 +: CH_W];
  assign a_reg = addr[3:2];
  assign a_ok  = (addr[1:0] == 2'b00) && (addr[STRIDE_LOG2-1:4] == '0);

  assign ctl_in.en  = wr_data[CTL_EN_BIT];
  assign ctl_in.rep = wr_data[CTL_REP_BIT];
  assign ctl_in.ps  = wr_data[CTL_PS_LSB +: 2];
  assign unused_hi  = ^wr_data[DATA_W-1:CNT_W];

  for (genvar i = 0; i < N_TMR; i++) begin : g_ch
    assign ch_sel[i] = a_ok && (a_ch == CH_W'(i));
    assign ld_we[i]  = wr_en && ch_sel[i] && (a_reg == REG_RELOAD);
    assign ctl_we[i] = wr_en && ch_sel[i] && (a_reg == REG_CTRL);
    assign clr_we[i] = wr_en && ch_sel[i] && (a_reg == REG_CLEAR);
    assign en_all[i]  = ctrl_all[i].en;
    assign rep_all[i] = ctrl_all[i].rep;

    tmr_channel #(
      .CNT_W    (CNT_W),
      .MID_LOG2 (MID_LOG2),
      .HI_LOG2  (HI_LOG2)
    ) u_ch (
      .clk      (clk),
      .rst      (rst),
      .ld_we    (ld_we[i]),
      .ld_val   (wr_data[CNT_W-1:0]),
      .ctl_we   (ctl_we[i]),
      .ctl_val  (ctl_in),
      .clr_we   (clr_we[i]),
      .reload_o (reload_all[i]),
      .count_o  (count_all[i]),
      .ctrl_o   (ctrl_all[i]),
      .pend_o   (pend_all[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if (ch_sel[i]) begin
        case (a_reg)
          REG_RELOAD: rd_mux = DATA_W'(reload_all[i]);
          REG_COUNT:  rd_mux = DATA_W'(count_all[i]);
          REG_CTRL: begin
            rd_mux[CTL_EN_BIT]        = ctrl_all[i].en;
            rd_mux[CTL_REP_BIT]       = ctrl_all[i].rep;
            rd_mux[CTL_PS_LSB +: 2]   = ctrl_all[i].ps;
          end
          default:    rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_mux;
      irq <= |pend_all;
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int N_TMR = 2,
  parameter int CNT_W = 24
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        irq,
  input logic [N_TMR-1:0]            pend,
  input logic [N_TMR-1:0][CNT_W-1:0] cnt,
  input logic [N_TMR-1:0][CNT_W-1:0] reload,
  input logic [N_TMR-1:0]            en,
  input logic [N_TMR-1:0]            rep,
  input logic [N_TMR-1:0]            ld_we,
  input logic [N_TMR-1:0]            clr_we
);
  for (genvar i = 0; i < N_TMR; i++) begin : g_chk
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
      (en[i] && !ld_we[i] && cnt[i] != '0) |=>
        (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) - 1'b1 ||
         cnt[i] == $past(reload[i]))); // R3
    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!rep[i] && cnt[i] == '0 && !ld_we[i]) |=> (cnt[i] == '0)); // R4
    AST_PEND_FROM_ONE: assert property (@(posedge clk) disable iff (rst)
      $rose(pend[i]) |-> ($past(cnt[i]) == CNT_W'(1))); // R5
    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (!en[i] && !ld_we[i]) |=> $stable(cnt[i])); // R6
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
      (pend[i] && !clr_we[i]) |=> pend[i]); // R7
  end

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(pend) != '0)); // R8
endmodule

bind dual_tick_timer tmr_checker #(
  .N_TMR (N_TMR),
  .CNT_W (CNT_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .irq    (irq),
  .pend   (pend_all),
  .cnt    (count_all),
  .reload (reload_all),
  .en     (en_all),
  .rep    (rep_all),
  .ld_we  (ld_we),
  .clr_we (clr_we)
);

// File: tb/tb_dual_tick_timer.sv
module tb_dual_tick_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  int t = 0; // edges since last reload write

  dual_tick_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    t += n;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    t += 1;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    t += 1;
  endtask

  function automatic logic [5:0] ra(int ch, int off);
    return 6'(ch * 32 + off);
  endfunction

  function automatic logic [31:0] exp_cnt(int l, int ps, bit rep, int tt);
    int dv;
    int k;
    dv = (ps == 0) ? 1 : (ps == 1) ? 16 : 256;
    k = tt / dv;
    if (rep) return 32'(l - (k % l));
    return (k >= l) ? 32'd0 : 32'(l - k);
  endfunction

  // reload write leaves t=0 at the following negedge
  task automatic load(int ch, logic [31:0] v);
    wr(ra(ch, 0), v);
    t = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int ch = 0; ch < 2; ch++)
      for (int off = 0; off < 16; off += 4) begin
        rd(ra(ch, off), d);
        chk("R1 reg after reset", d, 0);
      end
    chk("R1 irq after reset", {31'b0, irq}, 0);

    // R2 / R9 / R10: map, truncation, ignored writes
    load(0, 32'hFFFF_FFFF);
    rd(ra(0, 0), d); chk("R2 reload truncated", d, 32'h00FF_FFFF);
    rd(ra(0, 4), d); chk("R2 count copied", d, 32'h00FF_FFFF);
    wr(ra(1, 8), 32'hFFFF_FFFF);
    rd(ra(1, 8), d); chk("R9 ctrl readback", d, 32'h0000_00CC);
    idle(3);
    chk("R10 rd_data holds", rd_data, 32'h0000_00CC);
    wr(ra(1, 8), 0);
    wr(6'h10, 32'h55);
    wr(6'h01, 32'h7);
    rd(ra(0, 0), d); chk("R9 ignored writes", d, 32'h00FF_FFFF);
    rd(6'h10, d); chk("R9 gap reads zero", d, 0);
    rd(ra(0, 12), d); chk("R9 clear reads zero", d, 0);

    // R3: max value counts down at divide by 1
    wr(ra(0, 8), 32'h80);
    load(0, 32'h00FF_FFFF);
    idle(5);
    rd(ra(0, 4), d); chk("R3 max countdown", d, 32'h00FF_FFFA);
    wr(ra(0, 8), 0);

    // R4 / R8: one-shot L=5 div1
    wr(ra(0, 8), 32'h80);
    load(0, 5);
    idle(5); chk("R8 irq not yet", {31'b0, irq}, 0);
    idle(1); chk("R4 irq after zero", {31'b0, irq}, 1);
    rd(ra(0, 4), d); chk("R4 count at zero", d, 0);
    idle(10);
    rd(ra(0, 4), d); chk("R4 count stays zero", d, 0);
    wr(ra(0, 12), 32'hDEAD_BEEF);
    chk("R8 irq one stage late", {31'b0, irq}, 1);
    idle(1); chk("R7 clear any data", {31'b0, irq}, 0);

    // R5: repeat mode, div16, L=4
    wr(ra(0, 8), 32'hC4);
    load(0, 4);
    rd(ra(0, 4), d); chk("R5 t0", d, exp_cnt(4, 1, 1, 0));
    idle(14);
    rd(ra(0, 4), d); chk("R5 t15", d, exp_cnt(4, 1, 1, 15));
    rd(ra(0, 4), d); chk("R5 t16", d, exp_cnt(4, 1, 1, 16));
    idle(46);
    rd(ra(0, 4), d); chk("R5 t63", d, exp_cnt(4, 1, 1, 63));
    rd(ra(0, 4), d); chk("R5 reload t64", d, 4);
    chk("R5 pending raised", {31'b0, irq}, 1);

    // R6: disable keeps pending, freezes count
    wr(ra(0, 8), 0);
    idle(2); chk("R6 pending kept", {31'b0, irq}, 1);
    wr(ra(1, 8), 32'h80);
    load(1, 100);
    idle(5);
    wr(ra(1, 8), 0);
    idle(10);
    rd(ra(1, 4), d); chk("R6 count frozen", d, 94);
    wr(ra(0, 12), 0);
    idle(1); chk("R7 ch0 cleared", {31'b0, irq}, 0);

    // R7: clear only own timer
    wr(ra(1, 8), 32'h80);
    load(1, 2);
    idle(4); chk("R8 ch1 drives irq", {31'b0, irq}, 1);
    wr(ra(0, 12), 0);
    idle(1); chk("R7 other clear no effect", {31'b0, irq}, 1);
    wr(ra(1, 12), 0);
    idle(1); chk("R7 own clear", {31'b0, irq}, 0);
    wr(ra(1, 8), 0);

    // R7: set wins over same-cycle clear
    wr(ra(0, 8), 32'h80);
    load(0, 3);
    idle(2);
    wr(ra(0, 12), 0);
    idle(1); chk("R7 set wins", {31'b0, irq}, 1);
    wr(ra(0, 8), 0);
    wr(ra(0, 12), 0);

    // R3 / R4 / R5: random runs
    for (int it = 0; it < 40; it++) begin
      int ch;
      int ps;
      bit rp;
      int l;
      int m;
      ch = int'($urandom % 2);
      ps = int'($urandom % 4);
      rp = 1'($urandom % 2);
      l  = int'($urandom % 50) + 1;
      m  = int'($urandom % 400);
      wr(ra(ch, 8), 32'h80 | (32'(rp) << 6) | (32'(ps) << 2));
      load(ch, 32'(l));
      idle(m);
      rd(ra(ch, 4), d);
      chk(rp ? "R5 random repeat" : "R3 random oneshot", d, exp_cnt(l, ps, rp, m));
      wr(ra(ch, 8), 0);
      wr(ra(ch, 12), 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule